// File: doc/BRIEF.md
# Transmit Interrupt Moderator with Utilization Bands

This block decides when one transmit queue raises a completion interrupt. It has two separate sources. The first is a utilization source. At the end of every link sampling period, the block takes the utilization reported for that period and picks one of several bands with it. It then compares the number of frames completed since the last utilization interrupt with that band's frame-count threshold. The second is an interval timer. It counts microsecond ticks and fires either when transmit traffic occurred during the interval or, in continuous mode, at every interval.

When auto-cancel is set, a utilization interrupt restarts the timer. A single global enable silences both sources and clears their state. Each source drives its own one-cycle pulse, and a combined line is the OR of the two pulses. The block does not measure utilization, decode registers or handle the host's acknowledgement.

Top module: `tx_irq_moderator`

## Requirements
- R1: Band i (0 to NUM_BANDS-2) has a limit in field i of `cfg_band_limit` (PCT_W bits at bit i*PCT_W). The selected band is the lowest-numbered band whose limit is at or above `util_pct`. If no limit qualifies, the last band (NUM_BANDS-1) is selected.
- R2: In a cycle with `util_valid` high and `cfg_enable` high, the utilization source fires when the frame count is at or above the selected band's threshold. The threshold for band i is CNT_W bits at bit i*CNT_W of `cfg_band_thresh`. When the source fires, `util_irq` is high for exactly the next cycle. It is low in every other cycle.
- R3: The frame counter adds one for each cycle with `frame_done` high and saturates at 2^CNT_W-1. When the utilization source fires, the counter restarts. A frame that completes in the firing cycle counts as 1 toward the next period.
- R4: With `cfg_continuous` low and interval N>0, the timer fires on the Nth `us_tick` since its last restart, but only if `frame_done` was high in some cycle of that interval (the firing cycle included). `timer_irq` is high for the cycle after that tick. The count then restarts and the traffic record is cleared.
- R5: With `cfg_continuous` high, the timer fires on every Nth tick whether or not traffic occurred.
- R6: With `cfg_auto_cancel` high, a cycle in which the utilization source fires restarts the timer count and clears its traffic record. If that cycle is also the timer's expiry tick, the restart wins and no timer pulse occurs.
- R7: `cfg_interval` = 0 disables the timer source. `timer_irq` stays low.
- R8: While `cfg_enable` is low, neither pulse occurs, and the frame counter, timer count and traffic record are held at zero.
- R9: `irq` equals `util_irq` OR `timer_irq` in every cycle.
- R10: During and directly after reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One transmitted frame completed this cycle |
| util_pct | input | PCT_W | Link utilization of the period that ends this cycle, in percent |
| util_valid | input | 1 | End of a utilization sampling period |
| us_tick | input | 1 | One-microsecond tick |
| cfg_enable | input | 1 | Global enable for both sources |
| cfg_band_limit | input | (NUM_BANDS-1)*PCT_W | Upper utilization limit of each band except the last |
| cfg_band_thresh | input | NUM_BANDS*CNT_W | Frame-count threshold of each band |
| cfg_interval | input | TMR_W | Timer interval in ticks; 0 disables the timer |
| cfg_auto_cancel | input | 1 | Utilization interrupt restarts the timer |
| cfg_continuous | input | 1 | Timer fires whether or not there was traffic |
| util_irq | output | 1 | Utilization interrupt pulse |
| timer_irq | output | 1 | Timer interrupt pulse |
| irq | output | 1 | Combined interrupt line |

## Verification
Each source has one register between its trigger and its pulse. `util_irq` rises in the cycle after the `util_valid` cycle that fires it. `timer_irq` rises in the cycle after the expiring tick, and `irq` follows both with no further delay. The bench changes inputs on the falling edge and samples all three outputs on the next falling edge. Each observation therefore refers to exactly one stimulus cycle. The observation after it confirms that the pulse lasted one cycle. The band sweep covers every utilization value with frame counts on both sides of each threshold, and uses two limit orderings. The timer sweeps cover intervals 1 to 4, tick spacings 1 and 2, and every frame position, with a cycle-by-cycle expectation.

// File: rtl/imod_pkg.sv
package imod_pkg;

   // Per-cycle action of the interval timer, in priority order.
   typedef enum logic [2:0] {
      TMR_OFF,     // disabled or zero interval: hold cleared
      TMR_CANCEL,  // utilization interrupt restarts the interval
      TMR_EXPIRE,  // last tick of the interval
      TMR_COUNT,   // tick inside the interval
      TMR_WAIT     // no tick this cycle
   } tmr_act_e;

   localparam int unsigned PCT_FULL = 100;

endpackage

// File: rtl/imod_band_select.sv
module imod_band_select #(
   parameter int unsigned NUM_BANDS = 4,
   parameter int unsigned PCT_W     = 7,
   localparam int unsigned BAND_W   = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [PCT_W-1:0]                 util_pct,
   input  logic [(NUM_BANDS-1)*PCT_W-1:0]   band_limit,
   output logic [BAND_W-1:0]                band
);

   localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);

   logic [NUM_BANDS-2:0] hit;

   // One comparator per limited band.
   generate
      for (genvar g = 0; g < NUM_BANDS - 1; g++) begin : g_cmp
         assign hit[g] = (util_pct <= band_limit[g*PCT_W +: PCT_W]);
      end
   endgenerate

   // Lowest qualifying band wins; none qualifying falls to the last band.
   always_comb begin
      band = LAST_BAND;
      for (int i = NUM_BANDS - 2; i >= 0; i--) begin
         if (hit[i]) band = BAND_W'(i);
      end
   end

   assert_band_qualifies_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (band != LAST_BAND) |-> hit[band]);

   assert_last_band_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (band == LAST_BAND) |-> (hit[NUM_BANDS-2] == 1'b0 || NUM_BANDS == 2 || hit == '0));

endmodule

// File: rtl/imod_util_trigger.sv
module imod_util_trigger #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             frame_done,
   input  logic             period_end,
   input  logic [CNT_W-1:0] thresh,
   output logic             fire,
   output logic             pulse
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("imod_util_trigger: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign fire = enable && period_end && (cnt_q >= thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= fire;
         if (!enable) begin
            cnt_q <= '0;
         end else if (fire) begin
            cnt_q <= frame_done ? CNT_ONE : '0;
         end else if (frame_done && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
         end
      end
   end

   assert_pulse_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(period_end));

   assert_count_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt_q <= CNT_ONE));

   assert_count_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !fire && frame_done && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

   assert_count_held_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt_q == '0));

endmodule

// File: rtl/imod_interval_timer.sv
module imod_interval_timer
   import imod_pkg::*;
#(
   parameter int unsigned TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic             frame_done,
   input  logic [TMR_W-1:0] interval,
   input  logic             continuous,
   input  logic             auto_cancel,
   input  logic             util_fire,
   output logic             pulse
);

   localparam int unsigned EXT_W = TMR_W + 1;

   generate
      if (TMR_W < 1) begin : g_bad_width
         $error("imod_interval_timer: TMR_W must be at least 1");
      end
   endgenerate

   logic [TMR_W-1:0] cnt_q;
   logic             traffic_q;
   logic [EXT_W-1:0] cnt_inc;
   tmr_act_e         act;

   assign cnt_inc = EXT_W'(cnt_q) + EXT_W'(1);

   always_comb begin
      if (!enable || interval == '0)        act = TMR_OFF;
      else if (auto_cancel && util_fire)    act = TMR_CANCEL;
      else if (tick)                        act = (cnt_inc >= EXT_W'(interval)) ? TMR_EXPIRE : TMR_COUNT;
      else                                  act = TMR_WAIT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         traffic_q <= 1'b0;
         pulse     <= 1'b0;
      end else begin
         pulse <= 1'b0;
         unique case (act)
            TMR_OFF: begin
               cnt_q     <= '0;
               traffic_q <= 1'b0;
            end
            TMR_CANCEL: begin
               cnt_q     <= '0;
               traffic_q <= frame_done;
            end
            TMR_EXPIRE: begin
               cnt_q     <= '0;
               traffic_q <= 1'b0;
               pulse     <= traffic_q || frame_done || continuous;
            end
            TMR_COUNT: begin
               cnt_q     <= cnt_inc[TMR_W-1:0];
               traffic_q <= traffic_q || frame_done;
            end
            default: begin
               traffic_q <= traffic_q || frame_done;
            end
         endcase
      end
   end

   assert_pulse_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(tick));

   assert_zero_interval_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (interval == '0) |=> !pulse);

   assert_cancel_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && auto_cancel && util_fire) |=> !pulse);

   assert_continuous_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act == TMR_EXPIRE && continuous) |=> pulse);

endmodule

// File: rtl/tx_irq_moderator.sv
module tx_irq_moderator #(
   parameter int unsigned NUM_BANDS = 4,
   parameter int unsigned PCT_W     = 7,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned TMR_W     = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           frame_done,
   input  logic [PCT_W-1:0]               util_pct,
   input  logic                           util_valid,
   input  logic                           us_tick,
   input  logic                           cfg_enable,
   input  logic [(NUM_BANDS-1)*PCT_W-1:0] cfg_band_limit,
   input  logic [NUM_BANDS*CNT_W-1:0]     cfg_band_thresh,
   input  logic [TMR_W-1:0]               cfg_interval,
   input  logic                           cfg_auto_cancel,
   input  logic                           cfg_continuous,
   output logic                           util_irq,
   output logic                           timer_irq,
   output logic                           irq
);

   localparam int unsigned BAND_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1;

   generate
      if (NUM_BANDS < 2 || NUM_BANDS > 16) begin : g_bad_bands
         $error("tx_irq_moderator: NUM_BANDS must be 2..16");
      end
      if ((1 << PCT_W) <= imod_pkg::PCT_FULL) begin : g_bad_pct
         $error("tx_irq_moderator: PCT_W too narrow for a full-scale percentage");
      end
   endgenerate

   logic [BAND_W-1:0] band;
   logic [CNT_W-1:0]  sel_thresh;
   logic              util_fire;

   imod_band_select #(
      .NUM_BANDS (NUM_BANDS),
      .PCT_W     (PCT_W)
   ) u_band (
      .clk        (clk),
      .rst_n      (rst_n),
      .util_pct   (util_pct),
      .band_limit (cfg_band_limit),
      .band       (band)
   );

   assign sel_thresh = cfg_band_thresh[band*CNT_W +: CNT_W];

   imod_util_trigger #(
      .CNT_W (CNT_W)
   ) u_util (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_enable),
      .frame_done (frame_done),
      .period_end (util_valid),
      .thresh     (sel_thresh),
      .fire       (util_fire),
      .pulse      (util_irq)
   );

   imod_interval_timer #(
      .TMR_W (TMR_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (cfg_enable),
      .tick        (us_tick),
      .frame_done  (frame_done),
      .interval    (cfg_interval),
      .continuous  (cfg_continuous),
      .auto_cancel (cfg_auto_cancel),
      .util_fire   (util_fire),
      .pulse       (timer_irq)
   );

   assign irq = util_irq | timer_irq;

   assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!util_irq && !timer_irq));

   assert_util_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      util_irq |-> $past(cfg_enable));

endmodule

// File: tb/tx_irq_moderator_test.sv
`timescale 1ns/1ps
module tx_irq_moderator_test;

   localparam int NB = 4;
   localparam int PW = 7;
   localparam int CW = 16;
   localparam int TW = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n;
   logic              frame_done;
   logic [PW-1:0]     util_pct;
   logic              util_valid;
   logic              us_tick;
   logic              cfg_enable;
   logic [(NB-1)*PW-1:0] cfg_band_limit;
   logic [NB*CW-1:0]  cfg_band_thresh;
   logic [TW-1:0]     cfg_interval;
   logic              cfg_auto_cancel;
   logic              cfg_continuous;
   logic              util_irq, timer_irq, irq;

   tx_irq_moderator #(.NUM_BANDS(NB), .PCT_W(PW), .CNT_W(CW), .TMR_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .util_pct(util_pct),
      .util_valid(util_valid), .us_tick(us_tick), .cfg_enable(cfg_enable),
      .cfg_band_limit(cfg_band_limit), .cfg_band_thresh(cfg_band_thresh),
      .cfg_interval(cfg_interval), .cfg_auto_cancel(cfg_auto_cancel),
      .cfg_continuous(cfg_continuous), .util_irq(util_irq), .timer_irq(timer_irq),
      .irq(irq));

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   task automatic chk(input logic act, input logic exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
      end
   endtask

   task automatic obs(input logic eu, input logic et, input string what);
      chk(util_irq, eu, {what, " util_irq"});
      chk(timer_irq, et, {what, " timer_irq"});
      chk(irq, eu | et, {what, " R9 irq"});
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clr();
      cfg_enable = 1'b0; frame_done = 1'b0; util_valid = 1'b0; us_tick = 1'b0;
      step();
      cfg_enable = 1'b1;
   endtask

   function automatic int band_of(input int u, input int l0, input int l1, input int l2);
      if (u <= l0) return 0;
      if (u <= l1) return 1;
      if (u <= l2) return 2;
      return 3;
   endfunction

   task automatic set_thresh(input int t0, input int t1, input int t2, input int t3);
      cfg_band_thresh = {CW'(t3), CW'(t2), CW'(t1), CW'(t0)};
   endtask

   // Auto-cancel scenario: a frame in cycle 1, a period end in cycle sp, interval 4.
   task automatic run_ac(input logic ac, input logic cont, input int sp,
                         input int te, input string tag);
      cfg_interval = 4; cfg_auto_cancel = ac; cfg_continuous = cont;
      set_thresh(0, 0, 0, 0); util_pct = 0;
      clr();
      for (int i = 1; i <= 9; i++) begin
         us_tick = 1'b1; frame_done = (i == 1); util_valid = (i == sp);
         step();
         obs(i == sp, i == te, $sformatf("%s cycle %0d", tag, i));
      end
      us_tick = 1'b0; frame_done = 1'b0; util_valid = 1'b0;
   endtask

   initial begin
      #(5.0 * 190000);
      total++; bad++;
      $display("FAIL watchdog expired");
      if (!finished) $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; frame_done = 1'b0; util_pct = '0; util_valid = 1'b0; us_tick = 1'b0;
      cfg_enable = 1'b1; cfg_band_limit = '0; cfg_band_thresh = '0; cfg_interval = 1;
      cfg_auto_cancel = 1'b0; cfg_continuous = 1'b1;
      step(); step();
      obs(1'b0, 1'b0, "R10 in reset");
      rst_n = 1'b1;
      step();
      obs(1'b0, 1'b0, "R10 after reset");

      // R1/R2: every utilization value, frame counts 0..5, two limit orderings.
      cfg_interval = 0; cfg_continuous = 1'b0;
      set_thresh(1, 2, 3, 4);
      for (int pass = 0; pass < 2; pass++) begin
         int l0, l1, l2;
         l0 = (pass == 0) ? 20 : 60;
         l1 = (pass == 0) ? 50 : 30;
         l2 = (pass == 0) ? 80 : 100;
         cfg_band_limit = {PW'(l2), PW'(l1), PW'(l0)};
         for (int u = 0; u < 128; u++) begin
            for (int k = 0; k <= 5; k++) begin
               clr();
               for (int f = 0; f < k; f++) begin
                  frame_done = 1'b1;
                  step();
                  obs(1'b0, 1'b0, "R3 counting");
               end
               frame_done = 1'b0;
               util_pct = PW'(u); util_valid = 1'b1;
               step();
               obs(k >= band_of(u, l0, l1, l2) + 1, 1'b0,
                   $sformatf("R1/R2 util=%0d frames=%0d", u, k));
               util_valid = 1'b0;
               step();
               obs(1'b0, 1'b0, "R2 single-cycle pulse");
            end
         end
      end

      // R3: saturation, and a frame in the firing cycle carried over.
      cfg_band_limit = {PW'(80), PW'(50), PW'(20)};
      set_thresh(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      clr();
      frame_done = 1'b1;
      repeat (65540) step();
      util_pct = 127; util_valid = 1'b1;
      step();
      obs(1'b1, 1'b0, "R3 saturated count reaches max");
      util_valid = 1'b0; frame_done = 1'b0;
      set_thresh(16'hFFFF, 16'hFFFF, 16'hFFFF, 1);
      step();
      obs(1'b0, 1'b0, "R3 gap");
      util_valid = 1'b1;
      step();
      obs(1'b1, 1'b0, "R3 frame in firing cycle kept");
      util_valid = 1'b0;
      step();
      util_valid = 1'b1;
      step();
      obs(1'b0, 1'b0, "R3 count restarted");
      util_valid = 1'b0;

      // R4/R5: interval timer, cycle-by-cycle expectation.
      cfg_auto_cancel = 1'b0;
      for (int cont = 0; cont < 2; cont++) begin
         for (int n = 1; n <= 4; n++) begin
            for (int gap = 1; gap <= 2; gap++) begin
               for (int p = 0; p <= 8; p++) begin
                  int  tc;
                  bit  traf;
                  cfg_interval = TW'(n); cfg_continuous = cont[0];
                  clr();
                  tc = 0; traf = 1'b0;
                  for (int i = 1; i <= 12; i++) begin
                     bit tk, fd, ex;
                     tk = ((i % gap) == 0); fd = (i == p); ex = 1'b0;
                     us_tick = tk; frame_done = fd;
                     if (tk) begin
                        if (tc + 1 >= n) begin
                           ex = traf | fd | cont[0]; tc = 0; traf = 1'b0;
                        end else begin
                           tc++; traf = traf | fd;
                        end
                     end else begin
                        traf = traf | fd;
                     end
                     step();
                     obs(1'b0, ex, $sformatf("%s n=%0d gap=%0d frame@%0d cycle %0d",
                         cont ? "R5" : "R4", n, gap, p, i));
                  end
               end
            end
         end
      end
      us_tick = 1'b0; frame_done = 1'b0;

      // R7: zero interval never fires, even in continuous mode with traffic.
      cfg_interval = 0; cfg_continuous = 1'b1;
      clr();
      for (int i = 0; i < 20; i++) begin
         us_tick = 1'b1; frame_done = i[0];
         step();
         obs(1'b0, 1'b0, "R7 zero interval");
      end
      us_tick = 1'b0; frame_done = 1'b0;

      // R6: auto-cancel restarts the timer; same-cycle cancel beats expiry.
      run_ac(1'b1, 1'b0, 3, 0, "R6 cancel mid-interval");
      run_ac(1'b0, 1'b0, 3, 4, "R6 no cancel");
      run_ac(1'b1, 1'b0, 4, 0, "R6 cancel on expiry tick");
      run_ac(1'b0, 1'b0, 4, 4, "R6/R9 both sources together");
      run_ac(1'b1, 1'b1, 4, 8, "R6 continuous restart");

      // R8: global enable off silences everything and clears state.
      cfg_interval = 1; cfg_continuous = 1'b1; cfg_auto_cancel = 1'b0;
      set_thresh(0, 0, 0, 0); util_pct = 127;
      cfg_enable = 1'b0;
      for (int i = 0; i < 20; i++) begin
         us_tick = 1'b1; frame_done = 1'b1; util_valid = 1'b1;
         step();
         obs(1'b0, 1'b0, "R8 disabled");
      end
      set_thresh(0, 0, 0, 1);
      cfg_interval = 2; cfg_continuous = 1'b0;
      frame_done = 1'b0; util_valid = 1'b0; us_tick = 1'b1;
      cfg_enable = 1'b1;
      step();
      obs(1'b0, 1'b0, "R8 traffic record cleared");
      step();
      obs(1'b0, 1'b0, "R8 traffic record cleared");
      us_tick = 1'b0; util_valid = 1'b1;
      step();
      obs(1'b0, 1'b0, "R8 frame count cleared");
      util_valid = 1'b0;
      step();

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule